// File: doc/BRIEF.md
# Hybrid Cache Fill Router and Victim Picker

This block makes the per-set decisions for a two-level cache built from two memory technologies: a fast SRAM level and a dense nonvolatile last level. When a line returns from main memory after a miss, the block reads two prediction flags for that line: "dead" (it will not be touched again before eviction) and "write-burst" (it will be written often). It then issues one placement code. The code either skips the cache, keeps the line in the nonvolatile level, or places it there and then moves it to SRAM so that the nonvolatile array takes fewer writes.

When a set must give up a way, the block picks the victim from per-way valid, dead, dirty and age inputs. An empty way is used first. A predicted-dead way is used next. Otherwise the oldest way is taken. A writeback is requested only when the data being evicted is live and modified.

The data arrays, the tag compare and the predictor sit outside this block. Both outputs are registered and appear one clock after their request.

Top module: `hyb_fill_victim_sel`

## Requirements
- R1: While reset is held, and in the first cycle after it, placeValid, victimValid and wbReq are all 0.
- R2: A fill request with the dead flag set yields placeCode 2'b00 (bypass) one cycle later, whatever the write-burst flag is.
- R3: A fill request with neither flag set yields placeCode 2'b01 (keep in the nonvolatile level) one cycle later.
- R4: A fill request with write-burst set and dead clear yields placeCode 2'b10 (place in the nonvolatile level, then migrate to SRAM) one cycle later. The code 2'b11 is never issued.
- R5: placeValid is 1 for exactly the cycle after each cycle in which fillValid is 1, and is 0 otherwise.
- R6: If any way is invalid, the victim is the lowest-indexed invalid way.
- R7: If all ways are valid and at least one is flagged dead, the victim is the lowest-indexed dead way.
- R8: If all ways are valid and none is dead, the victim is the way with the largest age value (a larger value means less recently used). On a tie, the lower index wins.
- R9: wbReq is 1 only when the chosen victim is valid, dirty and not dead. In particular, a dirty dead victim raises no writeback.
- R10: victimValid is 1 for exactly the cycle after each cycle in which evictValid is 1. victimWay and wbReq are read in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fillValid | input | 1 | A fetched line needs a placement decision |
| fillDead | input | 1 | Predictor marks the fetched line dead |
| fillBurst | input | 1 | Predictor marks the fetched line write-burst |
| evictValid | input | 1 | A victim must be chosen from the set |
| wayValid | input | WAYS | Per-way valid bits |
| wayDead | input | WAYS | Per-way dead predictions |
| wayDirty | input | WAYS | Per-way dirty bits |
| wayAge | input | WAYS*AGE_W | Per-way age; way i occupies bits [i*AGE_W +: AGE_W] |
| placeValid | output | 1 | placeCode is meaningful this cycle |
| placeCode | output | 2 | 00 bypass, 01 nonvolatile, 10 nonvolatile then migrate to SRAM |
| victimValid | output | 1 | victimWay and wbReq are meaningful this cycle |
| victimWay | output | $clog2(WAYS) | Index of the chosen victim way |
| wbReq | output | 1 | Victim data must be written back |

## Verification
The hardest case to reach is a victim that is dirty and dead at the same time while an older, dirty, live way is also present. Only the dead-first priority stops that older way from being chosen and raising a writeback. The directed eviction scenarios set all ways valid and dirty and mark dead ways that are not the oldest. Separate scenarios cover age ties, mixed invalid and dead ways, and a dead flag paired with write-burst on a fill.

// File: rtl/hfv_pkg.sv
package hfv_pkg;
  typedef enum logic [1:0] {
    PL_BYPASS  = 2'b00,
    PL_NVM     = 2'b01,
    PL_NVM_MIG = 2'b10
  } place_e;

  typedef struct packed {
    logic evictStb;
  } hfv_strobe_t;
endpackage

// File: rtl/hfv_ctrl.sv
module hfv_ctrl
  import hfv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fillValid,
  input  logic        fillDead,
  input  logic        fillBurst,
  input  logic        evictValid,
  output hfv_strobe_t strobes,
  output logic        placeValid,
  output logic [1:0]  placeCode
);
  place_e nextCode;

  always_comb begin
    if (fillDead)       nextCode = PL_BYPASS;
    else if (fillBurst) nextCode = PL_NVM_MIG;
    else                nextCode = PL_NVM;
  end

  always_comb strobes.evictStb = evictValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      placeValid <= 1'b0;
      placeCode  <= PL_BYPASS;
    end else begin
      placeValid <= fillValid;
      if (fillValid) placeCode <= nextCode;
    end
  end

  // R2
  bypass_dead_chk: assert property (@(posedge clk) disable iff (!rstN)
    placeValid && $past(fillDead) |-> placeCode == 2'b00);
  // R4
  code_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    placeValid |-> placeCode != 2'b11);
  // R5
  place_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    placeValid |-> $past(fillValid));
endmodule

// File: rtl/hfv_dpath.sv
module hfv_dpath
  import hfv_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  hfv_strobe_t        strobes,
  input  logic [WAYS-1:0]    wayValid,
  input  logic [WAYS-1:0]    wayDead,
  input  logic [WAYS-1:0]    wayDirty,
  input  logic [WAYS*AGE_W-1:0] wayAge,
  output logic               victimValid,
  output logic [IDX_W-1:0]   victimWay,
  output logic               wbReq
);
  logic             invHit, deadHit;
  logic [IDX_W-1:0] invIdx, deadIdx, lruIdx, selIdx;
  logic [AGE_W-1:0] lruAge;
  logic             wbNext;

  always_comb begin
    invHit  = 1'b0;
    invIdx  = '0;
    deadHit = 1'b0;
    deadIdx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!wayValid[i]) begin
        invHit = 1'b1;
        invIdx = IDX_W'(i);
      end
      if (wayDead[i]) begin
        deadHit = 1'b1;
        deadIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    lruIdx = '0;
    lruAge = wayAge[AGE_W-1:0];
    for (int i = 1; i < WAYS; i++) begin
      if (wayAge[i*AGE_W +: AGE_W] > lruAge) begin
        lruAge = wayAge[i*AGE_W +: AGE_W];
        lruIdx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (invHit)       selIdx = invIdx;
    else if (deadHit) selIdx = deadIdx;
    else              selIdx = lruIdx;
    wbNext = wayValid[selIdx] & wayDirty[selIdx] & ~wayDead[selIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
      wbReq       <= 1'b0;
    end else begin
      victimValid <= strobes.evictStb;
      wbReq       <= strobes.evictStb & wbNext;
      if (strobes.evictStb) victimWay <= selIdx;
    end
  end

  // R9
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbReq |-> victimValid && $past(wayDirty != '0));
  // R10
  victim_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid |-> $past(strobes.evictStb));
  // R6
  inv_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid && $past(wayValid != '1) |->
      ((~$past(wayValid) >> victimWay) & WAYS'(1)) != '0);
  // R7
  dead_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    victimValid && $past(wayValid == '1) && $past(wayDead != '0) |->
      !wbReq && ((($past(wayDead) >> victimWay) & WAYS'(1)) != '0));
endmodule

// File: rtl/hyb_fill_victim_sel.sv
module hyb_fill_victim_sel
  import hfv_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int AGE_W = 2,
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  fillValid,
  input  logic                  fillDead,
  input  logic                  fillBurst,
  input  logic                  evictValid,
  input  logic [WAYS-1:0]       wayValid,
  input  logic [WAYS-1:0]       wayDead,
  input  logic [WAYS-1:0]       wayDirty,
  input  logic [WAYS*AGE_W-1:0] wayAge,
  output logic                  placeValid,
  output logic [1:0]            placeCode,
  output logic                  victimValid,
  output logic [IDX_W-1:0]      victimWay,
  output logic                  wbReq
);
  hfv_strobe_t strobes;

  hfv_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .fillValid(fillValid), .fillDead(fillDead), .fillBurst(fillBurst),
    .evictValid(evictValid), .strobes(strobes),
    .placeValid(placeValid), .placeCode(placeCode)
  );

  hfv_dpath #(.WAYS(WAYS), .AGE_W(AGE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wayValid(wayValid), .wayDead(wayDead), .wayDirty(wayDirty), .wayAge(wayAge),
    .victimValid(victimValid), .victimWay(victimWay), .wbReq(wbReq)
  );
endmodule

// File: tb/hyb_fill_victim_sel_tb_top.sv
module hyb_fill_victim_sel_tb_top;
  localparam int WAYS = 4;
  localparam int AGE_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fillValid = 0, fillDead = 0, fillBurst = 0, evictValid = 0;
  logic [WAYS-1:0] wayValid = '0, wayDead = '0, wayDirty = '0;
  logic [WAYS*AGE_W-1:0] wayAge = '0;
  logic placeValid, victimValid, wbReq;
  logic [1:0] placeCode, victimWay;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hyb_fill_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W)) dut_i (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .fillDead(fillDead),
    .fillBurst(fillBurst), .evictValid(evictValid), .wayValid(wayValid),
    .wayDead(wayDead), .wayDirty(wayDirty), .wayAge(wayAge),
    .placeValid(placeValid), .placeCode(placeCode),
    .victimValid(victimValid), .victimWay(victimWay), .wbReq(wbReq));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doFill(string req, logic dead, logic burst, int expCode);
    @(negedge clk);
    fillValid = 1; fillDead = dead; fillBurst = burst;
    @(negedge clk);
    fillValid = 0; fillDead = 0; fillBurst = 0;
    check(req, int'(placeValid), 1);
    check(req, int'(placeCode), expCode);
  endtask

  task automatic doEvict(string req, logic [3:0] v, logic [3:0] d, logic [3:0] dt,
                         logic [7:0] ages, int expWay, int expWb);
    @(negedge clk);
    evictValid = 1; wayValid = v; wayDead = d; wayDirty = dt; wayAge = ages;
    @(negedge clk);
    evictValid = 0;
    check(req, int'(victimValid), 1);
    check(req, int'(victimWay), expWay);
    check(req, int'(wbReq), expWb);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check("R1", int'(placeValid), 0);
    check("R1", int'(victimValid), 0);
    rstN = 1;
    @(negedge clk);
    check("R1", int'(wbReq), 0);
    doFill("R2", 1, 0, 0);
    doFill("R2", 1, 1, 0);
    doFill("R3", 0, 0, 1);
    doFill("R4", 0, 1, 2);
    @(negedge clk);
    check("R5", int'(placeValid), 0);
    // R6 lowest invalid way
    doEvict("R6", 4'b1011, 4'b0000, 4'b1111, 8'b11_10_01_00, 2, 0);
    doEvict("R6", 4'b0101, 4'b0100, 4'b1111, 8'b00_00_00_11, 1, 0);
    // R7 dead beats oldest, dirty dead gives no writeback (R9)
    doEvict("R7", 4'b1111, 4'b1010, 4'b1111, 8'b00_11_00_10, 1, 0);
    // R8 oldest way, dirty live gives writeback (R9)
    doEvict("R8", 4'b1111, 4'b0000, 4'b0100, 8'b01_11_10_00, 2, 1);
    // R8 tie goes to lower index, clean gives no writeback
    doEvict("R8", 4'b1111, 4'b0000, 4'b0101, 8'b11_00_11_10, 1, 0);
    doEvict("R9", 4'b1111, 4'b0000, 4'b0001, 8'b00_00_00_11, 0, 1);
    @(negedge clk);
    check("R10", int'(victimValid), 0);
    check("R10", int'(wbReq), 0);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule